// File: doc/BRIEF.md
# Prioritized Interrupt Vector Supplier

This peripheral collects a set of level-sensitive interrupt request lines, selects the highest-numbered active line, and signals the processor through a single interrupt request output. The processor answers with an active-low acknowledge that it pulses twice. The block then delivers an 8-bit interrupt type byte on a shared data bus, and it does so only during the second pulse.

The type byte is made from the winning line number: the top bit is set, the next three bits hold the inverted line number, and the low nibble is zero. The winner is captured at the start of the first acknowledge pulse, so the byte stays the same even if the request lines change while the handshake is under way. The bus output comes with an enable that stands in for a three-state driver, and the data output reads zero whenever the enable is low. The acknowledge input is sampled on the block clock, and every edge of it takes effect at the next clock edge.

Top module: `irq_vector_supplier`

## Requirements
- R1: While reset is held and right after it, `intr` and `bus_oe` are 0 and `bus_data` is 00h.
- R2: When the block is idle and any request line is sampled high at a clock edge, `intr` is 1 after that edge.
- R3: When several lines are active, the highest-numbered line wins. Line 7 has the highest priority and line 0 the lowest.
- R4: The type byte has bit 7 = 1, bits 6..4 = the bitwise inverse of the 3-bit winning line number, and bits 3..0 = 0. Line 2 gives D0h, line 7 gives 80h and line 0 gives F0h.
- R5: At the clock edge that samples the first falling edge of `ack_n` while a request is pending, `intr` goes to 0, and it stays 0 until the second pulse ends.
- R6: `bus_oe` is 1 only from the edge that samples the second falling edge of `ack_n` up to the edge that samples the rising edge that follows it. While `bus_oe` is 0, `bus_data` is 00h.
- R7: The winning line number is captured when the first falling edge is sampled. Request changes made after that point do not alter the byte delivered in the second pulse.
- R8: At the edge that samples the end of the second pulse, `intr` becomes 1 if any request line is high and stays 0 if none is.
- R9: A falling edge of `ack_n` sampled while no line is requesting is ignored: no sequence starts and `bus_oe` stays 0.
- R10: After a complete two-pulse sequence, the pulse count returns to its start value. The first pulse of the next acknowledge never drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | LINES (8) | Level-sensitive request lines; a higher index means higher priority |
| ack_n | input | 1 | Active-low acknowledge pulses from the processor |
| intr | output | 1 | Interrupt request to the processor |
| bus_data | output | DATA_W (8) | Type byte; 00h while not enabled |
| bus_oe | output | 1 | Bus drive enable, high only during the second acknowledge pulse |

## Verification
The assertions assume that `ack_n` is synchronous to `clk` and that each of its low and high phases lasts at least one clock. They also assume the processor only acknowledges after it has seen `intr`, so a pulse pair is never split by a reset. The stimulus changes every input on the falling clock edge and holds each acknowledge phase for one or two full cycles. It starts each handshake only after `intr` has been observed. Within that protocol, random request patterns are applied, and some of them are changed between the first and second pulses or during the second pulse.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Position within the two-pulse acknowledge handshake
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_GAP    = 2'd2,
    SEQ_SECOND = 2'd3
  } ack_phase_e;

  // Edge events extracted from the sampled acknowledge line
  typedef struct packed {
    logic fall;
    logic rise;
  } ack_edges_t;

endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic [LINES-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  logic [LINES-1:0] grant;

  // A line is granted when it is active and no higher line is active
  for (genvar g = 0; g < LINES; g++) begin : g_grant
    if (g == LINES - 1) begin : g_top
      assign grant[g] = req[g];
    end else begin : g_lower
      assign grant[g] = req[g] & ~(|req[LINES-1:g+1]);
    end
  end

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irqv_ack_seq.sv
module irqv_ack_seq
  import irqv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  input  logic any_pend,
  output logic latch_en,
  output logic drive_en,
  output logic intr,
  output logic busy
);

  ack_phase_e phase_q, phase_d;
  logic       ack_q;
  ack_edges_t edges;
  logic       intr_q;

  // Previous sample of the acknowledge line, idle-high after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_n;
  end

  assign edges.fall = ack_q & ~ack_n;
  assign edges.rise = ~ack_q & ack_n;

  always_comb begin
    phase_d  = phase_q;
    latch_en = 1'b0;
    unique case (phase_q)
      SEQ_IDLE: begin
        if (edges.fall && any_pend) begin
          phase_d  = SEQ_FIRST;
          latch_en = 1'b1;
        end
      end
      SEQ_FIRST:  if (edges.rise) phase_d = SEQ_GAP;
      SEQ_GAP:    if (edges.fall) phase_d = SEQ_SECOND;
      SEQ_SECOND: if (edges.rise) phase_d = SEQ_IDLE;
      default:    phase_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SEQ_IDLE;
      intr_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      intr_q  <= any_pend && (phase_d == SEQ_IDLE);
    end
  end

  assign drive_en = (phase_q == SEQ_SECOND);
  assign busy     = (phase_q != SEQ_IDLE);
  assign intr     = intr_q;

endmodule

// File: rtl/irqv_vector_reg.sv
module irqv_vector_reg #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              drive_en,
  output logic [DATA_W-1:0] data_out
);

  localparam int FIELD_HI = DATA_W - 2;

  logic [IDX_W-1:0] held_idx;

  // Marker bit on top, inverted line number below it, zero padding beneath
  function automatic logic [DATA_W-1:0] type_byte(input logic [IDX_W-1:0] k);
    logic [DATA_W-1:0] v;
    v = '0;
    v[DATA_W-1] = 1'b1;
    v[FIELD_HI -: IDX_W] = ~k;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_idx <= '0;
    else if (latch_en) held_idx <= idx_in;
  end

  assign data_out = drive_en ? type_byte(held_idx) : '0;

endmodule

// File: rtl/irq_vector_supplier.sv
module irq_vector_supplier #(
  parameter int LINES  = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_req,
  input  logic              ack_n,
  output logic              intr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe
);

  logic             any_pend;
  logic [IDX_W-1:0] win_idx;
  logic             latch_en;
  logic             drive_en;
  logic             ack_busy;

  irqv_prio_enc #(.LINES(LINES), .IDX_W(IDX_W)) u_enc (
    .req (irq_req),
    .any (any_pend),
    .idx (win_idx)
  );

  irqv_ack_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n    (ack_n),
    .any_pend (any_pend),
    .latch_en (latch_en),
    .drive_en (drive_en),
    .intr     (intr),
    .busy     (ack_busy)
  );

  irqv_vector_reg #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (latch_en),
    .idx_in   (win_idx),
    .drive_en (drive_en),
    .data_out (bus_data)
  );

  assign bus_oe = drive_en;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int LINES  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINES-1:0]  irq_req,
  input logic              ack_n,
  input logic              intr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_oe,
  input logic              ack_busy
);

  AST_OE_IN_LOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !$past(ack_n)); // R6

  AST_DATA_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0)); // R6

  AST_BYTE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_data[DATA_W-1] && bus_data[3:0] == 4'h0)); // R4

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_data)); // R7

  AST_NO_INTR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy |-> !intr); // R5

  AST_INTR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_oe) && $past(|irq_req)) |-> intr); // R8

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_busy && $past(irq_req) == '0 && !$past(ack_busy)) |-> !bus_oe); // R9

endmodule

bind irq_vector_supplier irqv_checker #(.LINES(LINES), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .ack_n    (ack_n),
  .intr     (intr),
  .bus_data (bus_data),
  .bus_oe   (bus_oe),
  .ack_busy (ack_busy)
);

// File: tb/irq_vector_supplier_tb.sv
module irq_vector_supplier_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = 8'h00;
  logic       ack_n = 1'b1;
  logic       intr;
  logic [7:0] bus_data;
  logic       bus_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_vector_supplier u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .ack_n    (ack_n),
    .intr     (intr),
    .bus_data (bus_data),
    .bus_oe   (bus_oe)
  );

  // Highest active line number
  function automatic int top_line(input logic [7:0] r);
    int w = 0;
    for (int i = 7; i >= 0; i--) begin
      if (r[i]) begin
        w = i;
        break;
      end
    end
    return w;
  endfunction

  // 80h plus (7 - line) placed in the upper nibble
  function automatic logic [7:0] expect_byte(input int line);
    return 8'h80 | 8'((7 - line) << 4);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Full handshake: req0 at start, req_mid applied in the gap, req_end during second pulse
  task automatic handshake(input logic [7:0] req0, input logic [7:0] req_mid,
                           input logic [7:0] req_end);
    logic [7:0] exp;
    exp = expect_byte(top_line(req0));
    @(negedge clk) irq_req = req0;
    @(negedge clk);
    chk("R2 intr raised", 8'(intr), 8'(req0 != 0));
    ack_n = 1'b0;
    @(negedge clk);
    chk("R5 intr dropped", 8'(intr), 8'h0);
    chk("R10 first pulse no drive", 8'(bus_oe), 8'h0);
    irq_req = req_mid;
    ack_n = 1'b1;
    @(negedge clk);
    chk("R5 intr low in gap", 8'(intr), 8'h0);
    @(negedge clk) ack_n = 1'b0;
    @(negedge clk);
    chk("R6 oe in second pulse", 8'(bus_oe), 8'h1);
    chk("R3 R4 R7 type byte", bus_data, exp);
    irq_req = req_end;
    @(negedge clk);
    chk("R7 byte held", bus_data, exp);
    ack_n = 1'b1;
    @(negedge clk);
    chk("R6 oe off after pulse", 8'(bus_oe), 8'h0);
    chk("R6 data zero", bus_data, 8'h00);
    chk("R8 intr after sequence", 8'(intr), 8'(req_end != 0));
    irq_req = 8'h00;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] a, b, c;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 intr in reset", 8'(intr), 8'h0);
    chk("R1 oe in reset", 8'(bus_oe), 8'h0);
    chk("R1 data in reset", bus_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 intr after reset", 8'(intr), 8'h0);

    // Single lines: line 2 must give D0h, line 7 80h, line 0 F0h
    for (int i = 0; i < 8; i++) handshake(8'(1 << i), 8'(1 << i), 8'h00);
    handshake(8'h04, 8'h00, 8'h00);
    chk("R4 line2 constant", expect_byte(2), 8'hD0);
    handshake(8'hFF, 8'h01, 8'h7F);          // R3 all active
    handshake(8'h05, 8'hF0, 8'h01);          // R3 R7 change mid
    handshake(8'h01, 8'h80, 8'h00);          // R7 higher line arrives late

    // R9: acknowledge pulses with nothing requested
    @(negedge clk) irq_req = 8'h00;
    for (int p = 0; p < 2; p++) begin
      @(negedge clk) ack_n = 1'b0;
      @(negedge clk);
      chk("R9 no drive without request", 8'(bus_oe), 8'h0);
      chk("R9 intr stays low", 8'(intr), 8'h0);
      @(negedge clk) ack_n = 1'b1;
      @(negedge clk);
    end
    handshake(8'h20, 8'h20, 8'h00);          // R10 fresh start after ignored pulses

    for (int n = 0; n < 60; n++) begin
      a = 8'($urandom);
      if (a == 8'h00) a = 8'h01;
      b = 8'($urandom);
      c = ($urandom % 2) ? 8'($urandom) : 8'h00;
      handshake(a, b, c);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule